// File: doc/BRIEF.md
# Graphics DRAM Mode Register and Latency Timer

This block is the command-timing core of a graphics DRAM device model. It watches a decoded command stream and the 12-bit address bus. On a mode-register-set command it takes new read and write latencies, a test-mode bit and a DLL-reset request from the address bits. Each later command is then timed against those settings.

A registered READ produces a one-cycle read-data-valid strobe a programmed number of clocks later. A registered WRITE produces a one-cycle write-capture strobe in the same way. Both strobes come from shift pipelines, so commands on consecutive clocks each get their own strobe. An ACT command turns on the data input receivers when the write latency is short.

A DLL-reset request runs a fixed-length internal busy period and then returns to normal mode without any further command. A latency code outside the legal set is rejected and reported, and the field keeps its previous value.

Top module: `gddr_mode_timer`

## Requirements
- R1: After reset the read latency is 5 and the write latency is 4. `test_mode_o`, `rx_en_o`, `dll_busy_o`, `cfg_err_o`, `rd_busy_err_o`, `rd_valid_o` and `wr_capture_o` are all low.
- R2: The command encoding on `cmd_i` is NOP=0, MRS=1, ACT=2, READ=3, WRITE=4. An MRS takes the read latency code from A6..A4 (codes 5, 6, 7 give latencies 5, 6, 7) and the write latency code from A11..A9 (codes 2, 3, 4 give latencies 2, 3, 4). It copies A7 to `test_mode_o`, where 1 means test mode and 0 means normal.
- R3: A READ registered at edge n with read latency m makes `rd_valid_o` high for exactly one cycle, sampled high at edge n+m.
- R4: A WRITE registered at edge n with write latency w makes `wr_capture_o` high for exactly one cycle, sampled high at edge n+w.
- R5: Commands on consecutive clocks each produce their own strobe. Each command uses the latency in force at the edge where it is registered, even if an MRS changes the latency before its strobe appears.
- R6: An ACT registered while the write latency is 2 or 3 sets `rx_en_o` from the next cycle. An ACT while the write latency is 4 leaves it low. `rx_en_o` is low by the second clock after an MRS that programs write latency 4.
- R7: An MRS with A8=1 raises `dll_busy_o` from the next cycle for exactly DLL_CYCLES clocks (default 16), after which it clears by itself. An MRS with A8=0 starts no busy period.
- R8: A READ registered while `dll_busy_o` is high makes `rd_busy_err_o` high in the following cycle. A READ registered while not busy leaves it low.
- R9: An MRS carrying a reserved code in a latency field leaves that field unchanged. A legal code in the other field is still taken. `cfg_err_o` is high after an MRS with any reserved code and low after an MRS with none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command: NOP=0, MRS=1, ACT=2, READ=3, WRITE=4 |
| addr_i | input | 12 | Address bus A11..A0, decoded on MRS |
| rd_valid_o | output | 1 | Read-data-valid strobe |
| wr_capture_o | output | 1 | Write-data-capture strobe |
| rx_en_o | output | 1 | Data input receiver enable |
| test_mode_o | output | 1 | Programmed test-mode bit |
| dll_busy_o | output | 1 | DLL-reset sequence in progress |
| cfg_err_o | output | 1 | Last MRS carried a reserved latency code |
| rd_busy_err_o | output | 1 | A READ was registered while the DLL was busy |

## Verification
The bench sweeps every legal pair of read and write latency. For each pair it finds the exact cycle of each strobe. A design that is off by one register, or that taps the wrong pipeline stage, shows up as a strobe one clock early or late.

Every reserved code is tried in each latency field while the other field stays legal. A design that loads reserved codes, or that rejects the whole MRS, then produces wrong strobe timing on the next READ or WRITE.

Back-to-back reads must give two strobes, not one merged pulse. A READ followed by an MRS that shortens the latency must keep the old timing, which catches a design that reads the latency at the output end of the pipeline.

The DLL busy period is counted to the exact clock. The receiver-enable path is checked for each write-latency setting.

// File: rtl/gddr_mt_pkg.sv
package gddr_mt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MRS   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4
  } cmd_e;

  // MRS field positions on the address bus
  localparam int RL_LSB   = 4;
  localparam int TEST_BIT = 7;
  localparam int DLL_BIT  = 8;
  localparam int WL_LSB   = 9;
  localparam int CODE_W   = 3;
endpackage

// File: rtl/gddr_mt_mode_reg.sv
module gddr_mt_mode_reg
  import gddr_mt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int RL_MIN = 5,
  parameter int RL_MAX = 7,
  parameter int WL_MIN = 2,
  parameter int WL_MAX = 4,
  parameter int RL_RST = 5,
  parameter int WL_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CODE_W-1:0] rl_o,
  output logic [CODE_W-1:0] wl_o,
  output logic              test_o,
  output logic              dll_req_o,
  output logic              cfg_err_o
);
  localparam logic [CODE_W-1:0] RL_LO = CODE_W'(RL_MIN);
  localparam logic [CODE_W-1:0] RL_HI = CODE_W'(RL_MAX);
  localparam logic [CODE_W-1:0] WL_LO = CODE_W'(WL_MIN);
  localparam logic [CODE_W-1:0] WL_HI = CODE_W'(WL_MAX);

  logic [CODE_W-1:0] rl_code, wl_code, rl_q, wl_q;
  logic              rl_ok, wl_ok, test_q, err_q;

  assign rl_code = addr_i[RL_LSB +: CODE_W];
  assign wl_code = addr_i[WL_LSB +: CODE_W];

  always_comb begin
    rl_ok = (rl_code >= RL_LO) && (rl_code <= RL_HI);
    wl_ok = (wl_code >= WL_LO) && (wl_code <= WL_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rl_q   <= CODE_W'(RL_RST);
      wl_q   <= CODE_W'(WL_RST);
      test_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (mrs_i) begin
      // reserved codes keep the previous legal value per field
      if (rl_ok) rl_q <= rl_code;
      if (wl_ok) wl_q <= wl_code;
      test_q <= addr_i[TEST_BIT];
      err_q  <= !(rl_ok && wl_ok);
    end
  end

  assign rl_o      = rl_q;
  assign wl_o      = wl_q;
  assign test_o    = test_q;
  assign cfg_err_o = err_q;
  assign dll_req_o = mrs_i && addr_i[DLL_BIT];

  p_rl_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rl_q >= RL_LO) && (rl_q <= RL_HI) && (wl_q >= WL_LO) && (wl_q <= WL_HI));

  p_reserved_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_i && !rl_ok) |=> ($stable(rl_o) && cfg_err_o));

  p_reserved_wl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_i && !wl_ok) |=> ($stable(wl_o) && cfg_err_o));
endmodule

// File: rtl/gddr_mt_lat_pipe.sv
module gddr_mt_lat_pipe #(
  parameter int MAX_LAT = 7,
  parameter int LAT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             strobe_o
);
  // countdown line: entry inserted at stage lat-1, strobe leaves stage 0
  logic [MAX_LAT-1:0] sr_q, sr_d;

  for (genvar k = 0; k < MAX_LAT; k++) begin : g_stage
    localparam logic [LAT_W-1:0] TAP = LAT_W'(k + 1);
    if (k == MAX_LAT - 1) begin : g_top
      assign sr_d[k] = fire_i && (lat_i == TAP);
    end else begin : g_mid
      assign sr_d[k] = sr_q[k+1] || (fire_i && (lat_i == TAP));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign strobe_o = sr_q[0];

  p_lat_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> ((lat_i != '0) && (lat_i <= LAT_W'(MAX_LAT))));
endmodule

// File: rtl/gddr_mt_dll_seq.sv
module gddr_mt_dll_seq #(
  parameter int CYCLES = 16,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_dll_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  p_dll_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/gddr_mode_timer.sv
module gddr_mode_timer
  import gddr_mt_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int RL_MIN     = 5,
  parameter int RL_MAX     = 7,
  parameter int WL_MIN     = 2,
  parameter int WL_MAX     = 4,
  parameter int WL_RX_MAX  = 3,
  parameter int DLL_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_valid_o,
  output logic              wr_capture_o,
  output logic              rx_en_o,
  output logic              test_mode_o,
  output logic              dll_busy_o,
  output logic              cfg_err_o,
  output logic              rd_busy_err_o
);
  localparam logic [CODE_W-1:0] RX_HI = CODE_W'(WL_RX_MAX);

  cmd_e              cmd;
  logic              is_mrs, is_act, is_rd, is_wr, dll_req;
  logic [CODE_W-1:0] rl, wl;
  logic              rx_q, rbe_q;

  assign cmd    = cmd_e'(cmd_i);
  assign is_mrs = (cmd == CMD_MRS);
  assign is_act = (cmd == CMD_ACT);
  assign is_rd  = (cmd == CMD_READ);
  assign is_wr  = (cmd == CMD_WRITE);

  gddr_mt_mode_reg #(
    .ADDR_W(ADDR_W), .RL_MIN(RL_MIN), .RL_MAX(RL_MAX),
    .WL_MIN(WL_MIN), .WL_MAX(WL_MAX), .RL_RST(RL_MIN), .WL_RST(WL_MAX)
  ) u_mode (
    .clk_i, .rst_ni, .mrs_i(is_mrs), .addr_i,
    .rl_o(rl), .wl_o(wl), .test_o(test_mode_o),
    .dll_req_o(dll_req), .cfg_err_o(cfg_err_o)
  );

  gddr_mt_lat_pipe #(.MAX_LAT(RL_MAX), .LAT_W(CODE_W)) u_rd_pipe (
    .clk_i, .rst_ni, .fire_i(is_rd), .lat_i(rl), .strobe_o(rd_valid_o)
  );

  gddr_mt_lat_pipe #(.MAX_LAT(WL_MAX), .LAT_W(CODE_W)) u_wr_pipe (
    .clk_i, .rst_ni, .fire_i(is_wr), .lat_i(wl), .strobe_o(wr_capture_o)
  );

  gddr_mt_dll_seq #(.CYCLES(DLL_CYCLES)) u_dll (
    .clk_i, .rst_ni, .start_i(dll_req), .busy_o(dll_busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= 1'b0;
      rbe_q <= 1'b0;
    end else begin
      if (is_act && (wl <= RX_HI)) rx_q <= 1'b1;
      else if (wl > RX_HI)         rx_q <= 1'b0;
      rbe_q <= is_rd && dll_busy_o;
    end
  end

  assign rx_en_o       = rx_q;
  assign rd_busy_err_o = rbe_q;

  for (genvar k = RL_MIN; k <= RL_MAX; k++) begin : g_rd_chk
    p_rd_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_rd && (rl == CODE_W'(k))) |-> ##k rd_valid_o);
  end

  for (genvar k = WL_MIN; k <= WL_MAX; k++) begin : g_wr_chk
    p_wr_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_wr && (wl == CODE_W'(k))) |-> ##k wr_capture_o);
  end

  p_rx_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && (wl <= RX_HI)) |=> rx_en_o);

  p_busy_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && dll_busy_o) |=> rd_busy_err_o);
endmodule

// File: tb/gddr_mode_timer_tb.sv
`timescale 1ns/1ps
module gddr_mode_timer_tb;
  localparam logic [2:0] NOP = 3'd0, MRS = 3'd1, ACT = 3'd2, RD = 3'd3, WR = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = NOP;
  logic [11:0] addr = '0;
  logic rd_valid, wr_cap, rx_en, test_mode, dll_busy, cfg_err, rd_busy_err;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gddr_mode_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .addr_i(addr),
    .rd_valid_o(rd_valid), .wr_capture_o(wr_cap), .rx_en_o(rx_en),
    .test_mode_o(test_mode), .dll_busy_o(dll_busy), .cfg_err_o(cfg_err),
    .rd_busy_err_o(rd_busy_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mrs_addr(int rl, int wl, int tm, int dll);
    logic [11:0] a = '0;
    a[6:4]  = rl[2:0];
    a[11:9] = wl[2:0];
    a[7]    = tm[0];
    a[8]    = dll[0];
    return a;
  endfunction

  // registers c at the next edge (edge n), returns just after it
  task automatic send(input logic [2:0] c, input logic [11:0] a);
    @(negedge clk);
    cmd = c; addr = a;
    @(posedge clk);
    #1 cmd = NOP; addr = '0;
  endtask

  // sample index k is the negedge following edge n+k
  task automatic probe(output int rd_first, output int rd_cnt,
                       output int wr_first, output int wr_cnt);
    rd_first = -1; rd_cnt = 0; wr_first = -1; wr_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (rd_valid) begin if (rd_first < 0) rd_first = k; rd_cnt++; end
      if (wr_cap)   begin if (wr_first < 0) wr_first = k; wr_cnt++; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rf, rc, wf, wc, busy_n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", rd_valid, 0);
    check("R1 wr_capture", wr_cap, 0);
    check("R1 rx_en", rx_en, 0);
    check("R1 test_mode", test_mode, 0);
    check("R1 dll_busy", dll_busy, 0);
    check("R1 cfg_err", cfg_err, 0);
    check("R1 rd_busy_err", rd_busy_err, 0);
    send(RD, '0); probe(rf, rc, wf, wc);
    check("R1 default read latency", rf, 4);
    send(WR, '0); probe(rf, rc, wf, wc);
    check("R1 default write latency", wf, 3);

    // R2/R3/R4 sweep over all legal latency pairs
    for (int rl = 5; rl <= 7; rl++) begin
      for (int wl = 2; wl <= 4; wl++) begin
        send(MRS, mrs_addr(rl, wl, (rl + wl) % 2, 0));
        @(negedge clk);
        check("R2 legal mrs err", cfg_err, 0);
        check("R2 test bit", test_mode, (rl + wl) % 2);
        send(RD, '0); probe(rf, rc, wf, wc);
        check("R3 read strobe cycle", rf, rl - 1);
        check("R3 read strobe width", rc, 1);
        check("R4 no write strobe on read", wc, 0);
        send(WR, '0); probe(rf, rc, wf, wc);
        check("R4 write strobe cycle", wf, wl - 1);
        check("R4 write strobe width", wc, 1);
        check("R3 no read strobe on write", rc, 0);
      end
    end

    // R5 back-to-back reads at latency 6
    send(MRS, mrs_addr(6, 3, 0, 0));
    @(negedge clk); cmd = RD;
    @(posedge clk); #1;
    @(posedge clk); #1 cmd = NOP;
    probe(rf, rc, wf, wc);
    check("R5 back-to-back first", rf, 4);
    check("R5 back-to-back count", rc, 2);
    // R5 back-to-back writes at latency 3
    @(negedge clk); cmd = WR;
    @(posedge clk); #1;
    @(posedge clk); #1 cmd = NOP;
    probe(rf, rc, wf, wc);
    check("R5 write pair first", wf, 1);
    check("R5 write pair count", wc, 2);
    // R5 latency captured at registration: READ at rl 7, then MRS to rl 5
    send(MRS, mrs_addr(7, 3, 0, 0));
    send(RD, '0);
    send(MRS, mrs_addr(5, 3, 0, 0));
    probe(rf, rc, wf, wc);
    check("R5 captured latency", rf, 5);
    check("R5 captured count", rc, 1);

    // R9 reserved read codes, write field legal
    for (int c = 0; c < 5; c++) begin
      send(MRS, mrs_addr(6, 3, 0, 0));
      send(MRS, mrs_addr(c, 2, 0, 0));
      @(negedge clk);
      check("R9 reserved rl flags err", cfg_err, 1);
      send(RD, '0); probe(rf, rc, wf, wc);
      check("R9 rl kept", rf, 5);
      send(WR, '0); probe(rf, rc, wf, wc);
      check("R9 legal wl taken", wf, 1);
    end
    // R9 reserved write codes, read field legal
    for (int c = 0; c < 8; c++) begin
      if (c >= 2 && c <= 4) continue;
      send(MRS, mrs_addr(6, 3, 0, 0));
      send(MRS, mrs_addr(7, c, 0, 0));
      @(negedge clk);
      check("R9 reserved wl flags err", cfg_err, 1);
      send(WR, '0); probe(rf, rc, wf, wc);
      check("R9 wl kept", wf, 2);
      send(RD, '0); probe(rf, rc, wf, wc);
      check("R9 legal rl taken", rf, 6);
    end
    send(MRS, mrs_addr(5, 4, 0, 0));
    @(negedge clk);
    check("R9 err cleared by legal mrs", cfg_err, 0);

    // R6 receiver enable
    send(ACT, '0); @(negedge clk);
    check("R6 act at wl4 no rx", rx_en, 0);
    for (int wl = 2; wl <= 3; wl++) begin
      send(MRS, mrs_addr(5, wl, 0, 0)); @(negedge clk);
      check("R6 rx off before act", rx_en, 0);
      send(ACT, '0); @(negedge clk);
      check("R6 act at low wl sets rx", rx_en, 1);
      send(MRS, mrs_addr(5, 4, 0, 0)); @(negedge clk); @(negedge clk);
      check("R6 wl4 clears rx", rx_en, 0);
    end

    // R7 DLL reset sequence length and self-clear
    send(MRS, mrs_addr(5, 4, 0, 1));
    busy_n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (dll_busy) busy_n++;
      if (k == 0) check("R7 busy right after mrs", dll_busy, 1);
    end
    check("R7 busy length", busy_n, 16);
    check("R7 self clear", dll_busy, 0);
    send(MRS, mrs_addr(5, 4, 0, 0));
    repeat (3) begin @(negedge clk); check("R7 A8=0 no busy", dll_busy, 0); end

    // R8 READ during busy flagged, outside busy not
    send(MRS, mrs_addr(5, 4, 0, 1));
    send(RD, '0); @(negedge clk);
    check("R8 read while busy flagged", rd_busy_err, 1);
    @(negedge clk);
    check("R8 flag one cycle", rd_busy_err, 0);
    repeat (20) @(negedge clk);
    send(RD, '0); @(negedge clk);
    check("R8 read when idle not flagged", rd_busy_err, 0);
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule